// File: doc/BRIEF.md
# Instruction Cache Control and Invalidation Sequencer

This block holds the control word of a small direct-mapped instruction cache with 32 lines of 16 bytes, and runs the logic around it. It holds the line valid bits, walks them clear after an invalidate command, and settles three questions for every lookup. Is it a hit? On a miss, does the bus fetch a whole line or one longword? May the returning fill data be written into the array? A default write-protect check flags write accesses when the cache region is read-only.

Software writes the control word through a plain write strobe and reads it back at any time. The fetch unit presents a lookup with a longword address and the tag compare result from the external tag RAM, and gets the verdict back in the same cycle. Completed line fills come back on a valid/ready port that names the line index. `fill_ready` is low for the whole invalidate walk. A fill held with `fill_valid` stays pending until `fill_ready` returns, and the fill is taken on the first cycle in which both are high. The lookup side has no back-pressure: every output depends only on the inputs and state of the current cycle.

Top module: `icache_ctl`

## Requirements
- R1: After reset the control word reads 0, `inv_busy` is 0 and no lookup reports a hit.
- R2: A control write with bit 24 set starts an invalidate walk. `inv_busy` is 1 for exactly 32 cycles, starting in the cycle after the write. A write with bit 24 clear starts nothing.
- R3: The walk clears one line valid bit per cycle, from index 0 up to index 31. After the walk, no line reports a hit until it is filled again.
- R4: Bit 24 and all unassigned bits (30:25, 23:11, 7, 5:2) read as 0. After writing all ones, the readback is 0x8000_0743.
- R5: Bit 31 enables the cache. A lookup cannot hit until one complete walk has finished since reset, whatever the value of bit 31.
- R6: While `inv_busy` is 1, every lookup misses and `fill_ready` is 0. A second invalidate command during a walk restarts it from index 0, so `inv_busy` then stays high for 32 cycles after the newer command.
- R7: Bit 9 = 1 makes accesses noncacheable. A noncacheable lookup never hits and reports `miss_alloc` = 0, and an accepted fill does not raise `fill_wr`.
- R8: For a cacheable read miss, `miss_line` (1 = whole line, 0 = one longword) follows fill policy bits 1:0 and the longword offset in address bits 1:0 of `lk_lw_addr`. Policy 00 gives a line for offsets 0–2. Policy 01 gives a line for offsets 0–1. Policies 10 and 11 always give a line.
- R9: For a noncacheable read miss, `miss_line` is 0 when bit 10 is 0. When bit 10 is 1, it follows the same policy table as R8.
- R10: When bit 6 is 1, a write lookup raises `acc_err` in the same cycle. When bit 6 is 0, or for a read, `acc_err` stays 0.
- R11: `bufw_en` equals stored bit 8.
- R12: A fill accepted while cacheable sets the valid bit of line `fill_idx`. A later lookup of that line with a tag match hits, provided the cache is enabled and R5 is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word readback |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_write | input | 1 | Lookup is a write access |
| lk_lw_addr | input | 7 | Longword address: [6:2] line index, [1:0] longword offset |
| lk_tag_hit | input | 1 | External tag compare matched |
| lk_hit | output | 1 | Lookup hits |
| miss_req | output | 1 | Read lookup missed, bus fetch needed |
| miss_line | output | 1 | Fetch size: 1 line, 0 longword |
| miss_alloc | output | 1 | Fill of this miss may be written to the array |
| acc_err | output | 1 | Write to a write-protected region |
| fill_valid | input | 1 | Completed line fill offered |
| fill_idx | input | 5 | Line index of the offered fill |
| fill_ready | output | 1 | Fill can be accepted |
| fill_wr | output | 1 | Accepted fill is written into the array |
| inv_busy | output | 1 | Invalidate walk running |
| bufw_en | output | 1 | Buffered write enable for the bus controller |

## Verification
Two things are hard to reach from the ports. One is a restart in the middle of a walk. The other is proving that lines really are clear afterwards, since valid bits are only visible through hits. The stimulus first fills all 32 lines and confirms each one hits. It then issues an invalidate, issues a second one ten cycles later, and checks that the busy window is 32 cycles from the second command. It then probes every index with a matching tag and expects a miss. The gating in R5 is exercised by enabling the cache and filling a line before any walk has run.

// File: rtl/icc_pkg.sv
package icc_pkg;

  // Control word field positions
  localparam int CW_W          = 32;
  localparam int BIT_ENABLE    = 31;
  localparam int BIT_INVAL     = 24;
  localparam int BIT_NC_BURST  = 10;
  localparam int BIT_NC_DEF    = 9;
  localparam int BIT_BUF_WR    = 8;
  localparam int BIT_WPROT     = 6;
  localparam int POL_LO        = 0;
  localparam int POL_W         = 2;
  localparam int LW_OFF_W      = 2;

  typedef struct packed {
    logic             enable;
    logic             nc_burst;
    logic             nc_default;
    logic             buf_wr;
    logic             wprot;
    logic [POL_W-1:0] fill_pol;
  } ctl_t;

  // Fetch size by fill policy and longword offset: 1 = whole line
  function automatic logic want_line(input logic [POL_W-1:0] pol,
                                     input logic [LW_OFF_W-1:0] off);
    logic r;
    case (pol)
      2'b00:   r = (off != 2'b11);
      2'b01:   r = ~off[1];
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/icc_ctl_reg.sv
module icc_ctl_reg
  import icc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CW_W-1:0] wdata,
  output ctl_t            ctl,
  output logic            inv_cmd,
  output logic [CW_W-1:0] rdata
);

  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q.enable     <= wdata[BIT_ENABLE];
      ctl_q.nc_burst   <= wdata[BIT_NC_BURST];
      ctl_q.nc_default <= wdata[BIT_NC_DEF];
      ctl_q.buf_wr     <= wdata[BIT_BUF_WR];
      ctl_q.wprot      <= wdata[BIT_WPROT];
      ctl_q.fill_pol   <= wdata[POL_LO +: POL_W];
    end
  end

  // Command bit is a pulse only; it is never stored
  assign inv_cmd = wr_en & wdata[BIT_INVAL];
  assign ctl     = ctl_q;

  // Unassigned and command bits are discarded
  logic unused_wbits;
  assign unused_wbits = ^{wdata[30:25], wdata[BIT_INVAL], wdata[23:11],
                          wdata[7], wdata[5:2]};

  always_comb begin
    rdata                      = '0;
    rdata[BIT_ENABLE]          = ctl_q.enable;
    rdata[BIT_NC_BURST]        = ctl_q.nc_burst;
    rdata[BIT_NC_DEF]          = ctl_q.nc_default;
    rdata[BIT_BUF_WR]          = ctl_q.buf_wr;
    rdata[BIT_WPROT]           = ctl_q.wprot;
    rdata[POL_LO +: POL_W]     = ctl_q.fill_pol;
  end

endmodule

// File: rtl/icc_inv_walk.sv
module icc_inv_walk #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inv_cmd,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  output logic [ENTRIES-1:0] valid,
  output logic               busy,
  output logic               clean
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic             busy_q;
  logic             clean_q;

  // Walk pointer and status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      busy_q  <= 1'b0;
      clean_q <= 1'b0;
    end else begin
      if (busy_q) begin
        ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        if (ptr_q == LAST) begin
          busy_q  <= 1'b0;
          clean_q <= 1'b1;
        end
      end
      if (inv_cmd) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
      end
    end
  end

  // Valid bits: after reset their state is unknown, modelled as all set
  for (genvar g = 0; g < ENTRIES; g++) begin : g_line
    logic v_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b1;
      end else if (busy_q && ptr_q == IDX_W'(g)) begin
        v_q <= 1'b0;
      end else if (set_en && set_idx == IDX_W'(g)) begin
        v_q <= 1'b1;
      end
    end
    assign valid[g] = v_q;
  end

  assign busy  = busy_q;
  assign clean = clean_q;

endmodule

// File: rtl/icc_miss_dec.sv
module icc_miss_dec
  import icc_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LA_W   = IDX_W + LW_OFF_W
) (
  input  ctl_t               ctl,
  input  logic               clean,
  input  logic               busy,
  input  logic [ENTRIES-1:0] valid,
  input  logic               lk_valid,
  input  logic               lk_write,
  input  logic [LA_W-1:0]    lk_lw_addr,
  input  logic               lk_tag_hit,
  output logic               lk_hit,
  output logic               miss_req,
  output logic               miss_line,
  output logic               miss_alloc,
  output logic               acc_err
);

  logic [IDX_W-1:0]    idx;
  logic [LW_OFF_W-1:0] off;
  logic                rd;
  logic                cacheable;
  logic                live;
  logic                pol_line;

  assign idx       = lk_lw_addr[LA_W-1:LW_OFF_W];
  assign off       = lk_lw_addr[LW_OFF_W-1:0];
  assign rd        = lk_valid & ~lk_write;
  assign cacheable = ~ctl.nc_default;
  assign live      = ctl.enable & clean & ~busy;
  assign pol_line  = want_line(ctl.fill_pol, off);

  always_comb begin
    lk_hit     = rd & live & cacheable & valid[idx] & lk_tag_hit;
    miss_req   = rd & ~lk_hit;
    miss_alloc = miss_req & cacheable;
    if (cacheable) miss_line = miss_req & pol_line;
    else           miss_line = miss_req & ctl.nc_burst & pol_line;
    acc_err    = lk_valid & lk_write & ctl.wprot;
  end

endmodule

// File: rtl/icache_ctl.sv
module icache_ctl
  import icc_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LA_W   = IDX_W + LW_OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic [CW_W-1:0] cfg_wdata,
  output logic [CW_W-1:0] cfg_rdata,
  input  logic            lk_valid,
  input  logic            lk_write,
  input  logic [LA_W-1:0] lk_lw_addr,
  input  logic            lk_tag_hit,
  output logic            lk_hit,
  output logic            miss_req,
  output logic            miss_line,
  output logic            miss_alloc,
  output logic            acc_err,
  input  logic            fill_valid,
  input  logic [IDX_W-1:0] fill_idx,
  output logic            fill_ready,
  output logic            fill_wr,
  output logic            inv_busy,
  output logic            bufw_en
);

  ctl_t               ctl;
  logic               inv_cmd;
  logic [ENTRIES-1:0] valid;
  logic               busy;
  logic               clean;

  icc_ctl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wdata   (cfg_wdata),
    .ctl     (ctl),
    .inv_cmd (inv_cmd),
    .rdata   (cfg_rdata)
  );

  icc_inv_walk #(.ENTRIES(ENTRIES)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .inv_cmd (inv_cmd),
    .set_en  (fill_wr),
    .set_idx (fill_idx),
    .valid   (valid),
    .busy    (busy),
    .clean   (clean)
  );

  icc_miss_dec #(.ENTRIES(ENTRIES)) u_dec (
    .ctl        (ctl),
    .clean      (clean),
    .busy       (busy),
    .valid      (valid),
    .lk_valid   (lk_valid),
    .lk_write   (lk_write),
    .lk_lw_addr (lk_lw_addr),
    .lk_tag_hit (lk_tag_hit),
    .lk_hit     (lk_hit),
    .miss_req   (miss_req),
    .miss_line  (miss_line),
    .miss_alloc (miss_alloc),
    .acc_err    (acc_err)
  );

  assign fill_ready = ~busy;
  assign fill_wr    = fill_valid & fill_ready & ~ctl.nc_default;
  assign inv_busy   = busy;
  assign bufw_en    = ctl.buf_wr;

endmodule

// File: rtl/icache_ctl_chk.sv
module icache_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        inv_busy,
  input logic        lk_valid,
  input logic        lk_write,
  input logic        lk_hit,
  input logic        miss_line,
  input logic        miss_alloc,
  input logic        acc_err,
  input logic        fill_ready,
  input logic        fill_wr
);

  // Cycles since the latest invalidate command
  logic [7:0] since_cmd;
  always_ff @(posedge clk) begin
    if (!rst_n)                           since_cmd <= '0;
    else if (cfg_wr_en && cfg_wdata[24])  since_cmd <= '0;
    else if (inv_busy && since_cmd != 8'hFF) since_cmd <= since_cmd + 8'd1;
  end

  a_r2_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wdata[24]) |=> inv_busy);

  a_r2_walk_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inv_busy) |-> since_cmd == 8'd32);

  a_r6_no_hit_busy: assert property (@(posedge clk) disable iff (!rst_n)
    inv_busy |-> !lk_hit);

  a_r6_no_fill_busy: assert property (@(posedge clk) disable iff (!rst_n)
    inv_busy |-> (!fill_ready && !fill_wr));

  a_r7_nc_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && cfg_rdata[9]) |-> (!lk_hit && !miss_alloc));

  a_r8_high_policy_line: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_write && !lk_hit && !cfg_rdata[9] && cfg_rdata[1]) |-> miss_line);

  a_r9_nc_single: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[9] && !cfg_rdata[10]) |-> !miss_line);

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (lk_valid && lk_write && cfg_rdata[6]));

endmodule

bind icache_ctl icache_ctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .inv_busy   (inv_busy),
  .lk_valid   (lk_valid),
  .lk_write   (lk_write),
  .lk_hit     (lk_hit),
  .miss_line  (miss_line),
  .miss_alloc (miss_alloc),
  .acc_err    (acc_err),
  .fill_ready (fill_ready),
  .fill_wr    (fill_wr)
);

// File: tb/icache_ctl_tb_top.sv
`timescale 1ns/1ps
module icache_ctl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0, lk_write = 1'b0, lk_tag_hit = 1'b0;
  logic [6:0]  lk_lw_addr = '0;
  logic        lk_hit, miss_req, miss_line, miss_alloc, acc_err;
  logic        fill_valid = 1'b0;
  logic [4:0]  fill_idx = '0;
  logic        fill_ready, fill_wr, inv_busy, bufw_en;

  always #2.5 clk = ~clk;

  icache_ctl dut_i (.*);

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // Reference state
  bit        m_en, m_burst, m_nc, m_bw, m_wp, m_busy, m_clean;
  bit [1:0]  m_pol;
  bit [31:0] m_v;
  int        m_ptr;

  function automatic bit ref_line(bit [1:0] pol, bit [1:0] off);
    int limit;
    limit = (pol == 2'd0) ? 3 : (pol == 2'd1) ? 2 : 4;
    return int'(off) < limit;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [4:0] idx;
    bit e_hit, e_miss, e_line;
    idx    = lk_lw_addr[6:2];
    e_hit  = lk_valid && !lk_write && m_en && m_clean && !m_busy && m_v[idx]
             && lk_tag_hit && !m_nc;
    e_miss = lk_valid && !lk_write && !e_hit;
    e_line = e_miss && (m_nc ? (m_burst && ref_line(m_pol, lk_lw_addr[1:0]))
                             : ref_line(m_pol, lk_lw_addr[1:0]));
    chk("R4",  cfg_rdata, {m_en, 6'd0, 1'b0, 13'd0, m_burst, m_nc, m_bw, 1'b0,
                           m_wp, 4'd0, m_pol}, "readback");
    chk("R2",  32'(inv_busy), 32'(m_busy), "inv_busy");
    chk("R5",  32'(lk_hit), 32'(e_hit), "lk_hit");
    chk("R6",  32'(miss_req), 32'(e_miss), "miss_req");
    chk("R8",  32'(miss_line), 32'(e_line), "miss_line");
    chk("R7",  32'(miss_alloc), 32'(e_miss && !m_nc), "miss_alloc");
    chk("R10", 32'(acc_err), 32'(lk_valid && lk_write && m_wp), "acc_err");
    chk("R6",  32'(fill_ready), 32'(!m_busy), "fill_ready");
    chk("R12", 32'(fill_wr), 32'(fill_valid && !m_busy && !m_nc), "fill_wr");
    chk("R11", 32'(bufw_en), 32'(m_bw), "bufw_en");
  endtask

  // Compare, take a clock edge, advance the reference
  task automatic tick();
    bit was_busy;
    #1;
    compare_all();
    @(posedge clk);
    was_busy = m_busy;
    if (fill_valid && !m_busy && !m_nc) m_v[fill_idx] = 1'b1;
    if (was_busy) begin
      m_v[m_ptr] = 1'b0;
      if (m_ptr == 31) begin m_busy = 0; m_clean = 1; end
      m_ptr = (m_ptr + 1) % 32;
    end
    if (cfg_wr_en) begin
      m_en = cfg_wdata[31]; m_burst = cfg_wdata[10]; m_nc = cfg_wdata[9];
      m_bw = cfg_wdata[8];  m_wp = cfg_wdata[6];     m_pol = cfg_wdata[1:0];
      if (cfg_wdata[24]) begin m_busy = 1; m_ptr = 0; end
    end
    #1;
  endtask

  task automatic wr(logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wdata = d;
    tick();
    cfg_wr_en = 1'b0; cfg_wdata = '0;
  endtask

  task automatic look(bit w, bit [4:0] idx, bit [1:0] off, bit th);
    lk_valid = 1'b1; lk_write = w; lk_lw_addr = {idx, off}; lk_tag_hit = th;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (inv_busy && n < 100) begin n++; tick(); end
  endtask

  initial begin
    int n;
    m_v = '1; m_ptr = 0;
    {m_en, m_burst, m_nc, m_bw, m_wp, m_busy, m_clean, m_pol} = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    #1;
    chk("R1", cfg_rdata, 32'h0, "readback after reset");
    chk("R1", 32'(inv_busy), 32'h0, "busy after reset");
    look(0, 5'd3, 2'd0, 1);
    tick();
    chk("R1", 32'(lk_hit), 32'h0, "hit after reset");

    // R5: enabled and filled, but no walk yet
    wr(32'h8000_0000);
    fill_valid = 1'b1; fill_idx = 5'd5; tick(); fill_valid = 1'b0;
    look(0, 5'd5, 2'd0, 1);
    tick();
    chk("R5", 32'(lk_hit), 32'h0, "hit before first walk");

    // R2: command bit clear starts nothing
    wr(32'h8000_0000);
    chk("R2", 32'(inv_busy), 32'h0, "busy after write with bit24=0");

    // R2: walk lasts 32 cycles, lookups miss meanwhile (R6)
    wr(32'h8100_0000);
    wait_idle(n);
    chk("R2", 32'(n), 32'd32, "busy cycles");

    // R12: fill every line and see hits
    for (int i = 0; i < 32; i++) begin
      fill_valid = 1'b1; fill_idx = 5'(i); tick();
    end
    fill_valid = 1'b0;
    for (int i = 0; i < 32; i++) begin
      look(0, 5'(i), 2'(i), 1); tick();
      chk("R12", 32'(lk_hit), 32'h1, "hit after fill");
    end

    // R6: restart mid-walk
    wr(32'h8100_0000);
    repeat (10) tick();
    wr(32'h8100_0000);
    wait_idle(n);
    chk("R6", 32'(n), 32'd32, "busy cycles after restart");

    // R3: every line clear after the walk
    for (int i = 0; i < 32; i++) begin
      look(0, 5'(i), 2'd1, 1); tick();
      chk("R3", 32'(lk_hit), 32'h0, "hit after invalidate");
    end

    // R4: all-ones write
    wr(32'hFFFF_FFFF);
    chk("R4", cfg_rdata, 32'h8000_0743, "readback of all ones");
    wait_idle(n);

    // R8: cacheable fetch size table
    for (int p = 0; p < 4; p++) begin
      wr(32'h8000_0000 | 32'(p));
      for (int o = 0; o < 4; o++) begin
        look(0, 5'd9, 2'(o), 0); tick();
        chk("R8", 32'(miss_line), 32'(ref_line(2'(p), 2'(o))), "line select");
      end
    end

    // R9 / R7: noncacheable, bursting off then on
    for (int b = 0; b < 2; b++) begin
      for (int p = 0; p < 4; p++) begin
        wr(32'h8000_0200 | (32'(b) << 10) | 32'(p));
        for (int o = 0; o < 4; o++) begin
          look(0, 5'd9, 2'(o), 0); tick();
          chk("R9", 32'(miss_line), 32'(b == 1 && ref_line(2'(p), 2'(o))), "nc line select");
          chk("R7", 32'(miss_alloc), 32'h0, "nc alloc");
        end
      end
    end
    fill_valid = 1'b1; fill_idx = 5'd12; tick();
    chk("R7", 32'(fill_wr), 32'h0, "nc fill write");
    fill_valid = 1'b0;
    wr(32'h8000_0000);
    look(0, 5'd12, 2'd0, 1); tick();
    chk("R7", 32'(lk_hit), 32'h0, "nc fill left line invalid");

    // R7: valid line, noncacheable mode, no hit
    fill_valid = 1'b1; fill_idx = 5'd13; tick(); fill_valid = 1'b0;
    wr(32'h8000_0200);
    look(0, 5'd13, 2'd0, 1); tick();
    chk("R7", 32'(lk_hit), 32'h0, "nc lookup on valid line");

    // R10: write protect
    wr(32'h8000_0040);
    look(1, 5'd2, 2'd0, 0); tick();
    chk("R10", 32'(acc_err), 32'h1, "write under protect");
    look(0, 5'd2, 2'd0, 0); tick();
    chk("R10", 32'(acc_err), 32'h0, "read under protect");
    wr(32'h8000_0000);
    look(1, 5'd2, 2'd0, 0); tick();
    chk("R10", 32'(acc_err), 32'h0, "write without protect");

    // R11: buffered write enable
    wr(32'h8000_0100);
    chk("R11", 32'(bufw_en), 32'h1, "bufw set");
    wr(32'h8000_0000);
    chk("R11", 32'(bufw_en), 32'h0, "bufw clear");

    lk_valid = 1'b0;
    tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule